// File: doc/BRIEF.md
# Lane-wise Pack and Unpack Unit

This unit rearranges two 256-bit source vectors into one 256-bit result. It treats each 128-bit half as a separate lane, so no element crosses from one half into the other. A two-bit mode picks one of four operations. The first is a saturating pack that narrows signed 16-bit elements to unsigned bytes. The second and third are low and high interleaves of 16-bit elements. The fourth widens unsigned bytes to 16 bits by zero extension. A caller presents both sources and the mode with `in_valid` high. The result appears in a register on the next clock edge, and `out_valid` is high for that cycle.

The output stage is a two-state machine. `ST_IDLE` means no result is being shown. `ST_SHOW` means the result register holds a value accepted on the previous edge. From either state, a cycle with `in_valid` high moves to `ST_SHOW` (transition *accept*). A cycle with `in_valid` low moves to `ST_IDLE` (transition *drain*). Reset enters `ST_IDLE`. Elements are numbered from the least significant end: 16-bit element i occupies bits [16i+15:16i], and byte i occupies bits [8i+7:8i].

Top module: `vpu_top`

## Requirements
- R1: In pack mode (`mode` = 2'b00), each 128-bit lane L of the result holds bytes in this order, from the low byte up: the narrowed `src_a` elements 8L..8L+7, then the narrowed `src_b` elements 8L..8L+7.
- R2: In pack mode, a source element whose signed value is above 255 narrows to 8'hFF.
- R3: In pack mode, a source element whose signed value is negative narrows to 8'h00. A value from 0 to 255 narrows to its low byte.
- R4: In unpack-low mode (`mode` = 2'b01), result elements 0..7 are a0,b0,a1,b1,a2,b2,a3,b3, and result elements 8..15 are a8,b8,a9,b9,a10,b10,a11,b11.
- R5: In unpack-high mode (`mode` = 2'b10), result elements 0..7 are a4,b4,a5,b5,a6,b6,a7,b7, and result elements 8..15 are a12,b12,a13,b13,a14,b14,a15,b15.
- R6: In zero-extend mode (`mode` = 2'b11), result element i (0..15) is {8'h00, byte i of `src_a`}. `src_b` and bits [255:128] of `src_a` have no effect.
- R7: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R8: While `in_valid` is low, `result` keeps its previous value whatever the sources and mode do.
- R9: During and right after reset, `result` is all zeros and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sources and mode are valid this cycle |
| mode | input | 2 | 00 pack, 01 unpack-low, 10 unpack-high, 11 zero-extend |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| out_valid | output | 1 | Result register holds a freshly accepted result |
| result | output | 256 | Registered result vector |

## Verification
A new operation can be accepted in the same cycle that the previous result is being presented. The bench provokes this by keeping `in_valid` high across consecutive edges while changing the mode every cycle. Each result is judged against an independent model one edge after its inputs, and `out_valid` must stay high throughout. Within a single pack, one lane also carries clamp-high, clamp-low and pass-through elements at the same time. The bench compares each of those bytes against hand-computed values.

// File: rtl/vpu_pkg.sv
package vpu_pkg;

    // Operation select, as carried on the mode port.
    typedef enum logic [1:0] {
        OP_PACK    = 2'b00,
        OP_UNPK_LO = 2'b01,
        OP_UNPK_HI = 2'b10,
        OP_ZEXT    = 2'b11
    } vpu_op_e;

    // Output stage state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } vpu_state_e;

endpackage

// File: rtl/vpu_sat_narrow.sv
module vpu_sat_narrow #(
    parameter int ELEM_W = 16
) (
    input  logic [ELEM_W-1:0]   wide,
    output logic [ELEM_W/2-1:0] narrow
);
    localparam int NW = ELEM_W / 2;

    // Signed input clamped into the unsigned range of a half-width field.
    always_comb begin
        if (wide[ELEM_W-1]) begin
            narrow = '0;
        end else if (|wide[ELEM_W-2:NW]) begin
            narrow = '1;
        end else begin
            narrow = wide[NW-1:0];
        end
    end
endmodule

// File: rtl/vpu_pack_lane.sv
module vpu_pack_lane #(
    parameter int LANE_W = 128,
    parameter int ELEM_W = 16
) (
    input  logic [LANE_W-1:0] a_lane,
    input  logic [LANE_W-1:0] b_lane,
    output logic [LANE_W-1:0] y_lane
);
    localparam int EPL = LANE_W / ELEM_W;
    localparam int NW  = ELEM_W / 2;

    // Low half of the lane takes the a elements, high half the b elements.
    for (genvar e = 0; e < EPL; e++) begin : g_elem
        vpu_sat_narrow #(.ELEM_W(ELEM_W)) u_sat_a (
            .wide   (a_lane[e*ELEM_W +: ELEM_W]),
            .narrow (y_lane[e*NW +: NW])
        );
        vpu_sat_narrow #(.ELEM_W(ELEM_W)) u_sat_b (
            .wide   (b_lane[e*ELEM_W +: ELEM_W]),
            .narrow (y_lane[(EPL+e)*NW +: NW])
        );
    end
endmodule

// File: rtl/vpu_interleave_lane.sv
module vpu_interleave_lane #(
    parameter int LANE_W = 128,
    parameter int ELEM_W = 16
) (
    input  logic [LANE_W-1:0] a_lane,
    input  logic [LANE_W-1:0] b_lane,
    input  logic              sel_hi,
    output logic [LANE_W-1:0] y_lane
);
    localparam int EPL  = LANE_W / ELEM_W;
    localparam int HALF = EPL / 2;

    logic [LANE_W-1:0] lo_mix;
    logic [LANE_W-1:0] hi_mix;

    // Even result slots take a, odd slots take b.
    for (genvar k = 0; k < HALF; k++) begin : g_pair
        assign lo_mix[(2*k)*ELEM_W   +: ELEM_W] = a_lane[k*ELEM_W +: ELEM_W];
        assign lo_mix[(2*k+1)*ELEM_W +: ELEM_W] = b_lane[k*ELEM_W +: ELEM_W];
        assign hi_mix[(2*k)*ELEM_W   +: ELEM_W] = a_lane[(HALF+k)*ELEM_W +: ELEM_W];
        assign hi_mix[(2*k+1)*ELEM_W +: ELEM_W] = b_lane[(HALF+k)*ELEM_W +: ELEM_W];
    end

    assign y_lane = sel_hi ? hi_mix : lo_mix;
endmodule

// File: rtl/vpu_zext.sv
module vpu_zext #(
    parameter int OUT_W  = 256,
    parameter int ELEM_W = 16
) (
    input  logic [OUT_W/2-1:0] src_lo,
    output logic [OUT_W-1:0]   y
);
    localparam int NW    = ELEM_W / 2;
    localparam int N_OUT = OUT_W / ELEM_W;

    for (genvar i = 0; i < N_OUT; i++) begin : g_widen
        assign y[i*ELEM_W +: ELEM_W] = {{NW{1'b0}}, src_lo[i*NW +: NW]};
    end
endmodule

// File: rtl/vpu_top.sv
module vpu_top #(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 128,
    parameter int ELEM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       mode,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    import vpu_pkg::*;

    localparam int NUM_LANES = VEC_W / LANE_W;

    logic [VEC_W-1:0] pack_y;
    logic [VEC_W-1:0] unpk_lo_y;
    logic [VEC_W-1:0] unpk_hi_y;
    logic [VEC_W-1:0] zext_y;
    logic [VEC_W-1:0] next_y;
    logic [VEC_W-1:0] result_q;

    vpu_op_e    op;
    vpu_state_e state_q;
    vpu_state_e state_d;

    assign op = vpu_op_e'(mode);

    // Per-lane datapaths; nothing crosses a lane boundary.
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        vpu_pack_lane #(.LANE_W(LANE_W), .ELEM_W(ELEM_W)) u_pack (
            .a_lane (src_a[l*LANE_W +: LANE_W]),
            .b_lane (src_b[l*LANE_W +: LANE_W]),
            .y_lane (pack_y[l*LANE_W +: LANE_W])
        );
        vpu_interleave_lane #(.LANE_W(LANE_W), .ELEM_W(ELEM_W)) u_mix_lo (
            .a_lane (src_a[l*LANE_W +: LANE_W]),
            .b_lane (src_b[l*LANE_W +: LANE_W]),
            .sel_hi (1'b0),
            .y_lane (unpk_lo_y[l*LANE_W +: LANE_W])
        );
        vpu_interleave_lane #(.LANE_W(LANE_W), .ELEM_W(ELEM_W)) u_mix_hi (
            .a_lane (src_a[l*LANE_W +: LANE_W]),
            .b_lane (src_b[l*LANE_W +: LANE_W]),
            .sel_hi (1'b1),
            .y_lane (unpk_hi_y[l*LANE_W +: LANE_W])
        );
    end

    vpu_zext #(.OUT_W(VEC_W), .ELEM_W(ELEM_W)) u_zext (
        .src_lo (src_a[VEC_W/2-1:0]),
        .y      (zext_y)
    );

    always_comb begin
        unique case (op)
            OP_PACK:    next_y = pack_y;
            OP_UNPK_LO: next_y = unpk_lo_y;
            OP_UNPK_HI: next_y = unpk_hi_y;
            OP_ZEXT:    next_y = zext_y;
            default:    next_y = '0;
        endcase
    end

    // Next-state logic: accept or drain.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (in_valid) begin
            result_q <= next_y;
        end
    end

    assign out_valid = (state_q == ST_SHOW);
    assign result    = result_q;
endmodule

// File: rtl/vpu_checker.sv
module vpu_checker #(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 128,
    parameter int ELEM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       mode,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);
    localparam int NW    = ELEM_W / 2;
    localparam int N_EL  = VEC_W / ELEM_W;

    logic all_neg;
    logic hi_bytes_clear;

    always_comb begin
        all_neg = 1'b1;
        for (int i = 0; i < N_EL; i++) begin
            all_neg = all_neg & src_a[i*ELEM_W + ELEM_W-1] & src_b[i*ELEM_W + ELEM_W-1];
        end
    end

    always_comb begin
        hi_bytes_clear = 1'b1;
        for (int i = 0; i < N_EL; i++) begin
            hi_bytes_clear = hi_bytes_clear & ~(|result[i*ELEM_W+NW +: NW]);
        end
    end

    p_valid_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_pack_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00 && all_neg) |=> (result == '0));

    p_pack_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00 && src_b[ELEM_W-1:NW] == '0)
        |=> (result[LANE_W/2 +: NW] == $past(src_b[NW-1:0])));

    p_unpk_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01)
        |=> (result[ELEM_W-1:0] == $past(src_a[ELEM_W-1:0]) &&
             result[2*ELEM_W-1:ELEM_W] == $past(src_b[ELEM_W-1:0])));

    p_unpk_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b10)
        |=> (result[ELEM_W-1:0] == $past(src_a[(LANE_W/2) +: ELEM_W]) &&
             result[2*ELEM_W-1:ELEM_W] == $past(src_b[(LANE_W/2) +: ELEM_W])));

    p_zext_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b11) |=> hi_bytes_clear);
endmodule

bind vpu_top vpu_checker #(.VEC_W(VEC_W), .LANE_W(LANE_W), .ELEM_W(ELEM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_vpu_top.sv
module tb_vpu_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic         out_valid;
    logic [255:0] result;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vpu_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    localparam int NVEC = 8;
    localparam logic [1:0]  T_MODE [0:NVEC-1] = '{2'b00, 2'b01, 2'b10, 2'b11,
                                                  2'b00, 2'b10, 2'b01, 2'b11};
    localparam logic [31:0] T_SEED [0:NVEC-1] = '{32'h0000_0001, 32'h1234_5678,
                                                  32'hDEAD_BEEF, 32'h0BAD_F00D,
                                                  32'h7700_00FF, 32'hA5A5_5A5A,
                                                  32'h0F0F_1234, 32'hCAFE_0042};

    function automatic logic [255:0] mk_vec(input logic [31:0] seed);
        logic [255:0] v;
        logic [31:0]  s;
        s = seed;
        for (int k = 0; k < 8; k++) begin
            s = s * 32'h0019_660D + 32'h3C6E_F35F;
            v[k*32 +: 32] = s;
        end
        return v;
    endfunction

    // Independent model written from the requirements.
    function automatic logic [255:0] ref_op(input logic [1:0] m,
                                            input logic [255:0] a,
                                            input logic [255:0] b);
        logic [255:0] r;
        r = '0;
        case (m)
            2'b00: for (int i = 0; i < 32; i++) begin
                int lane = i / 16;
                int pos = i % 16;
                logic [15:0] w;
                if (pos < 8) w = a[(lane*8 + pos)*16 +: 16];
                else         w = b[(lane*8 + pos - 8)*16 +: 16];
                if ($signed(w) < 0)        r[i*8 +: 8] = 8'h00;
                else if ($signed(w) > 255) r[i*8 +: 8] = 8'hFF;
                else                       r[i*8 +: 8] = w[7:0];
            end
            2'b01, 2'b10: for (int j = 0; j < 16; j++) begin
                int lane = j / 8;
                int k = (j % 8) / 2;
                int si = lane*8 + k + ((m == 2'b10) ? 4 : 0);
                r[j*16 +: 16] = (j % 2 == 0) ? a[si*16 +: 16] : b[si*16 +: 16];
            end
            default: for (int j = 0; j < 16; j++) begin
                r[j*16 +: 16] = {8'h00, a[j*8 +: 8]};
            end
        endcase
        return r;
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] m, input logic [255:0] a, input logic [255:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        mode = m;
        src_a = a;
        src_b = b;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [255:0] a;
        logic [255:0] b;
        logic [255:0] keep;
        logic [255:0] z1;

        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R9 result at reset", result, '0);
        chk("R9 out_valid at reset", {255'b0, out_valid}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 result after reset", result, '0);

        // Table walk (R1..R6 via model, R7 valid)
        for (int t = 0; t < NVEC; t++) begin
            a = mk_vec(T_SEED[t]);
            b = mk_vec(T_SEED[t] ^ 32'h5555_AAAA);
            issue(T_MODE[t], a, b);
            chk($sformatf("R1/R4/R5/R6 table %0d", t), result, ref_op(T_MODE[t], a, b));
            chk("R7 out_valid back-to-back", {255'b0, out_valid}, 256'd1);
        end

        // R2/R3/R1: saturation corners in one pack
        a = {2{16'h0001, 16'h0080, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0100, 16'h00FF, 16'h0000}};
        b = {{8{16'h0042}}, {8{16'h0105}}};
        issue(2'b00, a, b);
        chk("R2/R3 lane0 a bytes", {192'b0, result[63:0]}, {192'b0, 64'h0180_00FF_00FF_FF00});
        chk("R1 lane1 a bytes", {192'b0, result[191:128]}, {192'b0, 64'h0180_00FF_00FF_FF00});
        chk("R2 lane0 b clamp", {192'b0, result[127:64]}, {192'b0, 64'hFFFF_FFFF_FFFF_FFFF});
        chk("R1 lane1 b bytes", {192'b0, result[255:192]}, {192'b0, {8{8'h42}}});

        // R4/R5: element tracing
        for (int i = 0; i < 16; i++) begin
            a[i*16 +: 16] = 16'(i);
            b[i*16 +: 16] = 16'(16 + i);
        end
        issue(2'b01, a, b);
        chk("R4 first pair", {224'b0, result[31:0]}, {224'b0, 16'd16, 16'd0});
        chk("R4 lane1 start", {240'b0, result[143:128]}, {240'b0, 16'd8});
        issue(2'b10, a, b);
        chk("R5 first pair", {224'b0, result[31:0]}, {224'b0, 16'd20, 16'd4});
        chk("R5 last elem", {240'b0, result[255:240]}, {240'b0, 16'd31});

        // R6: b and upper a ignored
        for (int i = 0; i < 16; i++) a[i*8 +: 8] = 8'(i * 17);
        issue(2'b11, a, b);
        z1 = result;
        chk("R6 zext", z1, ref_op(2'b11, a, '0));
        issue(2'b11, {~a[255:128], a[127:0]}, ~b);
        chk("R6 b and upper a ignored", result, z1);

        // R8/R7: hold while idle
        keep = result;
        @(negedge clk);
        in_valid = 1'b0;
        mode = 2'b00;
        src_a = ~a;
        src_b = b ^ {8{32'hFFFF_0000}};
        @(posedge clk);
        #1;
        chk("R8 hold idle", result, keep);
        chk("R7 out_valid low", {255'b0, out_valid}, '0);
        @(posedge clk);
        #1;
        chk("R8 hold second idle", result, keep);

        // R7: re-accept after idle
        issue(2'b01, a, b);
        chk("R7 out_valid after idle", {255'b0, out_valid}, 256'd1);
        chk("R4 after idle", result, ref_op(2'b01, a, b));

        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule